// File: doc/BRIEF.md
# ECC error logging register block

This block sits next to the ECC checker of a memory controller. The checker reports each correctable and each uncorrectable error as a one-cycle pulse, together with the address that failed. The block keeps a saturating count for each error class. For uncorrectable errors it holds the first failing address. For correctable errors it holds the most recent one. It drives a level-sensitive, active-high interrupt while an enabled error class has a nonzero count.

Software reaches the block over a simple 32-bit register bus with word-aligned byte offsets. A single-cycle access is qualified by a select and a write strobe. Read data is registered and valid one cycle after the access. The configuration and interrupt-control registers can only be changed after software writes a magic value to the key register. Writing any other value to the key register shuts the door again. A clear bit in the interrupt-control register holds both counters and both address captures at zero for as long as it stays set.

Register offsets used by the bench: 0x00 key, 0x04 configuration, 0x50 interrupt control/status, 0x58 uncorrectable address, 0x5C correctable address.

Top module: `ecc_err_log`

## Requirements
- R1: After reset the block is in the following state. It is locked. The key register reads 0. The configuration register reads 0x00000080. The interrupt control/status register reads 0. Both address registers read 0. `irq` is low.
- R2: A write of 0xFC600309 to offset 0x00 unlocks the block. A write of any other value to offset 0x00 locks it. Offset 0x00 reads 1 while the block is unlocked and 0 while it is locked.
- R3: While the block is locked, writes to offsets 0x04 and 0x50 leave those registers unchanged.
- R4: The configuration register (0x04) stores only bit 7 (ECC enabled) and bit 4 (DRAM type, 1 = DDR4, 0 = DDR3). All other bits read 0.
- R5: The correctable count occupies bits 23:16 of offset 0x50. It increments once per correctable pulse and saturates at 255.
- R6: The uncorrectable count occupies bits 15:12 of offset 0x50. It increments once per uncorrectable pulse and saturates at 15.
- R7: Offset 0x58 holds the address of the first uncorrectable error since the last clear. Later uncorrectable errors do not overwrite it.
- R8: Offset 0x5C holds the address of the most recent correctable error.
- R9: Bit 0 of offset 0x50 enables the interrupt for correctable errors, and bit 1 enables it for uncorrectable errors. `irq` is high exactly when an enabled class has a nonzero count, one cycle after that count changes. `irq` stays high until the condition is cleared.
- R10: While bit 31 of offset 0x50 is 1, both counts and both address registers read 0 and error pulses are ignored. This includes a pulse that arrives in the same cycle as the write that sets bit 31. Bit 31 reads back as written.
- R11: `bus_rdata` is valid one cycle after a read. Offsets outside the map read 0. Writes to 0x58 and 0x5C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ce_pulse | input | 1 | Correctable error event |
| ce_addr | input | 32 | Address of the correctable error |
| ue_pulse | input | 1 | Uncorrectable error event |
| ue_addr | input | 32 | Address of the uncorrectable error |
| irq | output | 1 | Level interrupt, active high |

## Verification
The assertions check the following on every cycle:
- a saturated correctable count stays at its maximum;
- the uncorrectable count never steps by more than one;
- an active clear empties both counters on the next edge;
- the interrupt stays low with both enables off, and rises when the uncorrectable class is enabled and nonzero;
- the captured uncorrectable address stays still once the count is nonzero;
- the configuration cannot move while the block is locked.

Only the bench's scenarios can show some other behaviours. These are:
- the exact key value;
- the field positions of the register map;
- the most-recent rule of the correctable address;
- a clear write and an error pulse meeting in the same cycle.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;
  localparam int unsigned DW = 32;

  localparam logic [7:0] OFF_KEY  = 8'h00;
  localparam logic [7:0] OFF_CONF = 8'h04;
  localparam logic [7:0] OFF_CTRL = 8'h50;
  localparam logic [7:0] OFF_UEA  = 8'h58;
  localparam logic [7:0] OFF_CEA  = 8'h5C;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'hFC60_0309;

  localparam int unsigned CONF_ECC_BIT  = 7;
  localparam int unsigned CONF_DDR4_BIT = 4;
  localparam logic [DW-1:0] CONF_RESET = 32'h0000_0080;

  localparam int unsigned CTRL_CLR_BIT = 31;
  localparam int unsigned CE_LSB = 16;
  localparam int unsigned CE_W   = 8;
  localparam int unsigned UE_LSB = 12;
  localparam int unsigned UE_W   = 4;
  localparam int unsigned EN_W   = 2;
endpackage

// File: rtl/eel_lock.sv
module eel_lock #(
  parameter int unsigned        KW  = 32,
  parameter logic [KW-1:0]      KEY = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_wr,
  input  logic [KW-1:0] key_data,
  output logic          unlocked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (key_data == KEY);
    end
  end
endmodule

// File: rtl/eel_sat_counter.sv
module eel_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (inc && count != MAXV) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/eel_addr_capture.sv
module eel_addr_capture #(
  parameter int unsigned AW         = 32,
  parameter bit          FIRST_ONLY = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          evt,
  input  logic [AW-1:0] evt_addr,
  output logic [AW-1:0] addr_q
);
  logic held_q;
  logic take;

  generate
    if (FIRST_ONLY) begin : g_first
      assign take = evt && !held_q;
    end else begin : g_last
      assign take = evt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      addr_q <= '0;
      held_q <= 1'b0;
    end else if (take) begin
      addr_q <= evt_addr;
      held_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned BUS_AW = 8,
  parameter int unsigned ERR_AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ce_pulse,
  input  logic [ERR_AW-1:0] ce_addr,
  input  logic              ue_pulse,
  input  logic [ERR_AW-1:0] ue_addr,
  output logic              irq
);
  localparam int unsigned WIDX_W = BUS_AW - 2;
  localparam logic [WIDX_W-1:0] IDX_KEY  = WIDX_W'(OFF_KEY  >> 2);
  localparam logic [WIDX_W-1:0] IDX_CONF = WIDX_W'(OFF_CONF >> 2);
  localparam logic [WIDX_W-1:0] IDX_CTRL = WIDX_W'(OFF_CTRL >> 2);
  localparam logic [WIDX_W-1:0] IDX_UEA  = WIDX_W'(OFF_UEA  >> 2);
  localparam logic [WIDX_W-1:0] IDX_CEA  = WIDX_W'(OFF_CEA  >> 2);

  logic [WIDX_W-1:0] widx;
  logic              wr_any, wr_key, wr_ok, wr_conf, wr_ctrl;
  logic              unlocked;
  logic              conf_ecc_q, conf_ddr4_q;
  logic [DW-1:0]     conf_q;
  logic              clr_q;
  logic [EN_W-1:0]   en_q;
  logic              clear_now;
  logic [CE_W-1:0]   ce_cnt;
  logic [UE_W-1:0]   ue_cnt;
  logic [ERR_AW-1:0] ue_addr_q, ce_addr_q;
  logic [DW-1:0]     ctrl_view;
  logic [DW-1:0]     rd_mux;
  logic              unused_bits;

  assign widx    = bus_addr[BUS_AW-1:2];
  assign wr_any  = bus_sel && bus_wr;
  assign wr_key  = wr_any && (widx == IDX_KEY);
  assign wr_ok   = wr_any && unlocked;
  assign wr_conf = wr_ok && (widx == IDX_CONF);
  assign wr_ctrl = wr_ok && (widx == IDX_CTRL);
  assign unused_bits = ^{bus_addr[1:0]};

  eel_lock #(.KW(DW), .KEY(UNLOCK_KEY)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (wr_key),
    .key_data (bus_wdata),
    .unlocked (unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      conf_ecc_q  <= CONF_RESET[CONF_ECC_BIT];
      conf_ddr4_q <= CONF_RESET[CONF_DDR4_BIT];
    end else if (wr_conf) begin
      conf_ecc_q  <= bus_wdata[CONF_ECC_BIT];
      conf_ddr4_q <= bus_wdata[CONF_DDR4_BIT];
    end
  end

  always_comb begin
    conf_q = '0;
    conf_q[CONF_ECC_BIT]  = conf_ecc_q;
    conf_q[CONF_DDR4_BIT] = conf_ddr4_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_q <= 1'b0;
      en_q  <= '0;
    end else if (wr_ctrl) begin
      clr_q <= bus_wdata[CTRL_CLR_BIT];
      en_q  <= bus_wdata[EN_W-1:0];
    end
  end

  // A clear being written this cycle already blocks a coincident event.
  assign clear_now = clr_q || (wr_ctrl && bus_wdata[CTRL_CLR_BIT]);

  eel_sat_counter #(.W(CE_W)) u_ce_cnt (
    .clk (clk), .rst (rst), .clear (clear_now), .inc (ce_pulse), .count (ce_cnt)
  );

  eel_sat_counter #(.W(UE_W)) u_ue_cnt (
    .clk (clk), .rst (rst), .clear (clear_now), .inc (ue_pulse), .count (ue_cnt)
  );

  eel_addr_capture #(.AW(ERR_AW), .FIRST_ONLY(1'b1)) u_ue_cap (
    .clk (clk), .rst (rst), .clear (clear_now), .evt (ue_pulse),
    .evt_addr (ue_addr), .addr_q (ue_addr_q)
  );

  eel_addr_capture #(.AW(ERR_AW), .FIRST_ONLY(1'b0)) u_ce_cap (
    .clk (clk), .rst (rst), .clear (clear_now), .evt (ce_pulse),
    .evt_addr (ce_addr), .addr_q (ce_addr_q)
  );

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_CLR_BIT]            = clr_q;
    ctrl_view[CE_LSB +: CE_W]          = ce_cnt;
    ctrl_view[UE_LSB +: UE_W]          = ue_cnt;
    ctrl_view[EN_W-1:0]                = en_q;
  end

  always_comb begin
    unique case (widx)
      IDX_KEY:  rd_mux = DW'(unlocked);
      IDX_CONF: rd_mux = conf_q;
      IDX_CTRL: rd_mux = ctrl_view;
      IDX_UEA:  rd_mux = DW'(ue_addr_q);
      IDX_CEA:  rd_mux = DW'(ce_addr_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_sel && !bus_wr) begin
        bus_rdata <= rd_mux;
      end
      irq <= (en_q[0] && (ce_cnt != '0)) || (en_q[1] && (ue_cnt != '0));
    end
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int unsigned CW = 8,
  parameter int unsigned UW = 4,
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          unlocked,
  input logic [31:0]   conf_q,
  input logic          clear_now,
  input logic [CW-1:0] ce_cnt,
  input logic [UW-1:0] ue_cnt,
  input logic [1:0]    en_q,
  input logic          irq,
  input logic [AW-1:0] ue_addr_q
);
  localparam logic [CW-1:0] CE_MAX = '1;

  assert_locked_conf_R3: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable(conf_q));

  assert_ce_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (ce_cnt == CE_MAX && !clear_now) |=> (ce_cnt == CE_MAX));

  assert_ue_step_R6: assert property (@(posedge clk) disable iff (rst)
    !clear_now |=> (ue_cnt == $past(ue_cnt) || ue_cnt == $past(ue_cnt) + 1'b1));

  assert_ue_first_R7: assert property (@(posedge clk) disable iff (rst)
    (ue_cnt != '0 && !clear_now) |=> $stable(ue_addr_q));

  assert_irq_off_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q == 2'b00) |=> !irq);

  assert_irq_ue_R9: assert property (@(posedge clk) disable iff (rst)
    (en_q[1] && ue_cnt != '0) |=> irq);

  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clear_now |=> (ce_cnt == '0 && ue_cnt == '0));
endmodule

bind ecc_err_log ecc_err_log_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .unlocked  (unlocked),
  .conf_q    (conf_q),
  .clear_now (clear_now),
  .ce_cnt    (ce_cnt),
  .ue_cnt    (ue_cnt),
  .en_q      (en_q),
  .irq       (irq),
  .ue_addr_q (ue_addr_q)
);

// File: tb/ecc_err_log_test.sv
module ecc_err_log_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ce_pulse = 1'b0, ue_pulse = 1'b0;
  logic [31:0] ce_addr = '0, ue_addr = '0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];
  logic rd_pend = 1'b0;

  localparam logic [31:0] KEY = 32'hFC60_0309;

  always #4 clk = ~clk;

  ecc_err_log uut (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ce_pulse(ce_pulse), .ce_addr(ce_addr),
    .ue_pulse(ue_pulse), .ue_addr(ue_addr),
    .irq(irq)
  );

  // Monitor: compares registered read data one cycle after the read is sampled.
  always @(negedge clk) begin
    if (rd_pend) begin
      sb_item_t it;
      it = sbq.pop_front();
      n_checks++;
      if (bus_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
    rd_pend = bus_sel && !bus_wr;
  end

  task automatic idle();
    bus_sel = 1'b0; bus_wr = 1'b0;
    ce_pulse = 1'b0; ue_pulse = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    idle();
    wait (sbq.size() == 0);
  endtask

  task automatic ce_evt(input logic [31:0] a);
    @(posedge clk); #1;
    ce_pulse = 1'b1; ce_addr = a;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic ue_evt(input logic [31:0] a);
    @(posedge clk); #1;
    ue_pulse = 1'b1; ue_addr = a;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(posedge clk); #2;
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: actual irq %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk_irq(1'b0, "R1 irq");
    rd(8'h00, 32'h0, "R1 key");
    rd(8'h04, 32'h80, "R1 conf");
    rd(8'h50, 32'h0, "R1 ctrl");
    rd(8'h58, 32'h0, "R1 ue addr");
    rd(8'h5C, 32'h0, "R1 ce addr");
    rd(8'h10, 32'h0, "R11 unmapped");

    // R3 locked writes ignored
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h80, "R3 conf locked");
    wr(8'h50, 32'h3);
    rd(8'h50, 32'h0, "R3 ctrl locked");

    // R2 key
    wr(8'h00, ~KEY);
    rd(8'h00, 32'h0, "R2 wrong key");
    wr(8'h00, KEY);
    rd(8'h00, 32'h1, "R2 unlocked");

    // R4 config
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h90, "R4 conf mask");
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h10, "R4 ddr4 only");

    // R11 address regs read-only
    wr(8'h5C, 32'h1234_5678);
    rd(8'h5C, 32'h0, "R11 ce addr ro");

    // R8 / R9 correctable
    wr(8'h50, 32'h3);
    rd(8'h50, 32'h3, "R9 enables");
    ce_evt(32'hA000_0010);
    chk_irq(1'b1, "R9 ce irq");
    rd(8'h50, 32'h0001_0003, "R5 ce count 1");
    rd(8'h5C, 32'hA000_0010, "R8 ce addr 1");
    ce_evt(32'hA000_0020);
    rd(8'h5C, 32'hA000_0020, "R8 ce addr latest");
    rd(8'h50, 32'h0002_0003, "R5 ce count 2");

    // R10 clear
    wr(8'h50, 32'h8000_0003);
    chk_irq(1'b0, "R10 irq cleared");
    rd(8'h50, 32'h8000_0003, "R10 ctrl during clear");
    rd(8'h5C, 32'h0, "R10 ce addr cleared");
    ce_evt(32'hA000_0030);
    rd(8'h50, 32'h8000_0003, "R10 event ignored");
    wr(8'h50, 32'h3);

    // R7 / R6 uncorrectable
    ue_evt(32'hB000_0100);
    ue_evt(32'hB000_0200);
    rd(8'h58, 32'hB000_0100, "R7 first ue addr");
    rd(8'h50, 32'h0000_2003, "R6 ue count 2");
    chk_irq(1'b1, "R9 ue irq");

    // R3 lock again; write ignored, irq level held
    wr(8'h00, ~KEY);
    wr(8'h50, 32'h0);
    rd(8'h50, 32'h0000_2003, "R3 ctrl relocked");
    chk_irq(1'b1, "R9 irq level held");

    // R5 / R6 saturation
    for (int i = 0; i < 20; i++) ue_evt(32'hC000_0000 + i);
    for (int i = 0; i < 300; i++) ce_evt(32'hD000_0000 + i);
    rd(8'h50, 32'h00FF_F003, "R5 R6 saturated");
    rd(8'h58, 32'hB000_0100, "R7 first kept");
    rd(8'h5C, 32'hD000_012B, "R8 last of many");

    // R9 enable gating
    wr(8'h00, KEY);
    wr(8'h50, 32'h1);
    chk_irq(1'b1, "R9 ce only");
    wr(8'h50, 32'h2);
    chk_irq(1'b1, "R9 ue only");
    wr(8'h50, 32'h0);
    chk_irq(1'b0, "R9 disabled");
    wr(8'h50, 32'h8000_0000);
    wr(8'h50, 32'h2);
    ce_evt(32'hE000_0000);
    chk_irq(1'b0, "R9 ce masked");
    rd(8'h50, 32'h0001_0002, "R9 ce counted while masked");
    ue_evt(32'hE000_0100);
    chk_irq(1'b1, "R9 ue enabled");

    // R10 clear wins against a coincident event
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h50; bus_wdata = 32'h8000_0000;
    ce_pulse = 1'b1; ce_addr = 32'hF000_0001;
    ue_pulse = 1'b1; ue_addr = 32'hF000_0002;
    @(posedge clk); #1;
    idle();
    wr(8'h50, 32'h3);
    rd(8'h50, 32'h3, "R10 coincident event dropped");
    rd(8'h58, 32'h0, "R10 ue addr empty");
    rd(8'h5C, 32'h0, "R10 ce addr empty");
    chk_irq(1'b0, "R10 irq low");

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule